// File: doc/BRIEF.md
# Dual Timer: Countdown Event Timer and Free-Running Timebase

This peripheral sits on a plain 32-bit register bus in a single clock domain and offers two independent time services. A prescaler divides the bus clock down to a 2 MHz tick enable, and both timers advance only on that enable. The first service is a 56-bit countdown event timer. Software stages the low 32 bits of a reload value in one register. It then writes a control word whose low 24 bits carry the upper part of the value, and whose command bits start the countdown in single-shot or auto-repeat mode. When the count expires, a pending flag is set. That flag drives an interrupt line through a mask bit.

The second service is a 64-bit counter that never stops. Software reads it as two 32-bit words, the low word first. The low-word read freezes a copy of the upper half, so the two reads always form one consistent 64-bit sample.

The mask bit is changed only through separate write-one-to-set and write-one-to-clear registers. The pending flag is cleared through its own write-one register. Reads return data one cycle after the read strobe.

Top module: `dual_tick_timer`

## Requirements
- R1: A tick enable occurs once every `TICK_DIV` bus clocks. The free-running counter increases by exactly one per tick, so two low-word reads whose strobes are K·`TICK_DIV` clocks apart differ by exactly K.
- R2: A read at offset 0x024 returns counter bits [31:0] and captures bits [63:32] into a shadow. A read at offset 0x028 returns that shadow, which is zero until the counter first passes 2^32.
- R3: A write at 0x000 stages the low 32 bits of the reload value, and a read at 0x000 returns the staged word. A control write at 0x004 with bit 30 set commits {wdata[23:0], staged word} as the 56-bit reload value and loads it into the countdown. The upper 24 bits take part in the count.
- R4: With control bit 24 set, a loaded value N (N ≥ 1) expires on the Nth tick after the control write, between (N−1)·`TICK_DIV`+1 and N·`TICK_DIV` clocks later. In single-shot mode (bit 28 clear), expiry sets pending and the timer stops, so it does not expire again. With bit 24 clear, the timer does not count.
- R5: With control bit 28 set, expiry sets pending and reloads the stored value on the same tick, giving exactly N·`TICK_DIV` clocks between successive expiries.
- R6: Writing zero to the control register stops the event timer, and no further expiry occurs.
- R7: Writing a word with bit 0 set at 0x02C sets the mask. Writing a word with bit 0 set at 0x030 clears it. A word with bit 0 clear has no effect at either offset. Reads of either offset return the mask in bit 0.
- R8: The output `irq` equals pending AND mask. Pending stays set while masked, until a word with bit 0 set is written at 0x034. A read at 0x034 returns pending in bit 0.
- R9: Reads of offsets outside the seven mapped ones return zero. `bus_rdata` is zero in any cycle that does not follow a read strobe.
- R10: A read at 0x004 returns the reload upper bits in [23:0], the run state in bit 24 and the repeat setting in bit 28, with bit 30 reading zero. The run bit reads zero after a single-shot expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Event-timer interrupt, pending AND mask |

## Verification
A countdown that is off by one tick, or that drops the upper 24 reload bits, moves the interrupt edge. The interrupt then lands outside its window of one prescaler period, or far earlier than it should. A repeat reload that slips changes the measured expiry period on the very first repetition. A lost or sticky pending flag, or a mask bit that responds to a zero bit 0, shows at the next read of its offset or as an `irq` level that disagrees with the readback. A free counter that skips or stalls shows as a wrong difference between two low-word reads taken a known number of clocks apart.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 8;

    // control word command bit positions
    localparam int CTL_RUN  = 24;
    localparam int CTL_RPT  = 28;
    localparam int CTL_LOAD = 30;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_RLD_LO   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_FREE_LO  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_FREE_HI  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 8'h34;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RLD_LO,
        SEL_CTRL,
        SEL_FREE_LO,
        SEL_FREE_HI,
        SEL_MSK_SET,
        SEL_MSK_CLR,
        SEL_PEND_CLR
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_RLD_LO:   return SEL_RLD_LO;
            OFS_CTRL:     return SEL_CTRL;
            OFS_FREE_LO:  return SEL_FREE_LO;
            OFS_FREE_HI:  return SEL_FREE_HI;
            OFS_MSK_SET:  return SEL_MSK_SET;
            OFS_MSK_CLR:  return SEL_MSK_CLR;
            OFS_PEND_CLR: return SEL_PEND_CLR;
            default:      return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    generate
        if (TICK_DIV > 1) begin : g_div
            typedef struct packed {
                logic [CW-1:0] phase;
                logic          tick;
            } st_t;

            st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                st_d.tick = (st_q.phase == LAST);
                if (st_q.phase == LAST) st_d.phase = '0;
                else                    st_d.phase = st_q.phase + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tick = st_q.tick;

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end else begin : g_pass
            assign tick = rst_n;
        end
    endgenerate
endmodule

// File: rtl/dtt_free_counter.sv
module dtt_free_counter #(
    parameter int FREE_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rd_lo,
    output logic [WORD_W-1:0] lo_word,
    output logic [WORD_W-1:0] hi_shadow
);
    localparam int HI_W = FREE_W - WORD_W;

    typedef struct packed {
        logic [FREE_W-1:0] cnt;
        logic [HI_W-1:0]   shadow;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick)  st_d.cnt    = st_q.cnt + 1'b1;
        if (rd_lo) st_d.shadow = st_q.cnt[FREE_W-1:WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_word   = st_q.cnt[WORD_W-1:0];
    assign hi_shadow = WORD_W'(st_q.shadow);

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R1
    AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt)); // R1
    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (st_q.shadow == $past(st_q.cnt[FREE_W-1:WORD_W]))); // R2
endmodule

// File: rtl/dtt_event_timer.sv
module dtt_event_timer #(
    parameter int CNT_W = 56,
    parameter int LO_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  lo_wr,
    input  logic [LO_W-1:0]       lo_data,
    input  logic                  ctrl_wr,
    input  logic [CNT_W-LO_W-1:0] ctrl_hi,
    input  logic                  ctrl_run,
    input  logic                  ctrl_rpt,
    input  logic                  ctrl_load,
    input  logic                  clr_pend,
    output logic                  pend,
    output logic                  running,
    output logic                  repeat_on,
    output logic [CNT_W-LO_W-1:0] reload_hi,
    output logic [LO_W-1:0]       staged_lo
);
    localparam int HI_W = CNT_W - LO_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [LO_W-1:0]  lo;
        logic             run;
        logic             rpt;
        logic             pend;
    } st_t;

    st_t  st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (lo_wr) st_d.lo = lo_data;
        if (ctrl_wr) begin
            // a control write takes priority over a tick in the same cycle
            st_d.run = ctrl_run;
            st_d.rpt = ctrl_rpt;
            if (ctrl_load) begin
                st_d.rld = {ctrl_hi, st_q.lo};
                st_d.cnt = {ctrl_hi, st_q.lo};
            end
        end else if (st_q.run && tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                expire = 1'b1;
                if (st_q.rpt) begin
                    st_d.cnt = st_q.rld;
                end else begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        // a new expiry wins over a clear in the same cycle
        if (clr_pend) st_d.pend = 1'b0;
        if (expire)   st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend      = st_q.pend;
    assign running   = st_q.run;
    assign repeat_on = st_q.rpt;
    assign reload_hi = st_q.rld[CNT_W-1:LO_W];
    assign staged_lo = st_q.lo;

    AST_EVT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !ctrl_wr && st_q.cnt > CNT_W'(1))
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R4
    AST_EVT_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !ctrl_wr && st_q.cnt <= CNT_W'(1) && !st_q.rpt)
        |=> (!st_q.run && st_q.pend)); // R4
    AST_EVT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !ctrl_wr && st_q.cnt <= CNT_W'(1) && st_q.rpt)
        |=> (st_q.cnt == st_q.rld && st_q.pend && st_q.run)); // R5
    AST_EVT_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_pend) |=> st_q.pend); // R8
    AST_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !ctrl_wr) |=> ($stable(st_q.cnt) && !$rose(st_q.pend))); // R6
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
    parameter int TICK_DIV = 125,
    parameter int EVT_W    = 56,
    parameter int FREE_W   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import dtt_pkg::*;

    localparam int EVT_HI_W = EVT_W - BUS_W;

    typedef struct packed {
        logic             mask;
        logic [BUS_W-1:0] rdata;
    } st_t;

    st_t      st_d, st_q;
    reg_sel_e sel;
    logic     wr_s, rd_s;
    logic     tick;
    logic     lo_wr, ctrl_wr, pend_clr, free_rd_lo;
    logic     pend, running, repeat_on;
    logic [EVT_HI_W-1:0] reload_hi;
    logic [BUS_W-1:0]    staged_lo, free_lo, free_hi;
    logic [BUS_W-1:0]    ctrl_view;

    assign sel  = decode_ofs(bus_addr);
    assign wr_s = bus_en &&  bus_we;
    assign rd_s = bus_en && !bus_we;

    assign lo_wr      = wr_s && (sel == SEL_RLD_LO);
    assign ctrl_wr    = wr_s && (sel == SEL_CTRL);
    assign pend_clr   = wr_s && (sel == SEL_PEND_CLR) && bus_wdata[0];
    assign free_rd_lo = rd_s && (sel == SEL_FREE_LO);

    dtt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dtt_event_timer #(.CNT_W(EVT_W), .LO_W(BUS_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .lo_wr     (lo_wr),
        .lo_data   (bus_wdata),
        .ctrl_wr   (ctrl_wr),
        .ctrl_hi   (bus_wdata[EVT_HI_W-1:0]),
        .ctrl_run  (bus_wdata[CTL_RUN]),
        .ctrl_rpt  (bus_wdata[CTL_RPT]),
        .ctrl_load (bus_wdata[CTL_LOAD]),
        .clr_pend  (pend_clr),
        .pend      (pend),
        .running   (running),
        .repeat_on (repeat_on),
        .reload_hi (reload_hi),
        .staged_lo (staged_lo)
    );

    dtt_free_counter #(.FREE_W(FREE_W), .WORD_W(BUS_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rd_lo     (free_rd_lo),
        .lo_word   (free_lo),
        .hi_shadow (free_hi)
    );

    always_comb begin
        ctrl_view                 = '0;
        ctrl_view[EVT_HI_W-1:0]   = reload_hi;
        ctrl_view[CTL_RUN]        = running;
        ctrl_view[CTL_RPT]        = repeat_on;
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_s && sel == SEL_MSK_SET && bus_wdata[0]) st_d.mask = 1'b1;
        if (wr_s && sel == SEL_MSK_CLR && bus_wdata[0]) st_d.mask = 1'b0;
        if (rd_s) begin
            case (sel)
                SEL_RLD_LO:   st_d.rdata = staged_lo;
                SEL_CTRL:     st_d.rdata = ctrl_view;
                SEL_FREE_LO:  st_d.rdata = free_lo;
                SEL_FREE_HI:  st_d.rdata = free_hi;
                SEL_MSK_SET,
                SEL_MSK_CLR:  st_d.rdata = {{(BUS_W-1){1'b0}}, st_q.mask};
                SEL_PEND_CLR: st_d.rdata = {{(BUS_W-1){1'b0}}, pend};
                default:      st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = pend && st_q.mask;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.mask); // R8
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_s |=> (bus_rdata == '0)); // R9
    AST_MASK_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && !bus_wdata[0]) |=> $stable(st_q.mask)); // R7
endmodule

// File: tb/sim_dual_tick_timer.sv
module sim_dual_tick_timer;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_tick_timer #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        compared++;
        if (act < lo || act > hi) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_irq(input int limit, output bit seen);
        seen = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R8 irq low after reset", irq, 0);
        rd(8'h04, v); chk("R10 control reset", v, 0);
        rd(8'h2C, v); chk("R7 mask reset", v, 0);
        rd(8'h34, v); chk("R8 pending reset", v, 0);
        rd(8'h10, v); chk("R9 unmapped 0x10", v, 0);
        rd(8'h3C, v); chk("R9 unmapped 0x3C", v, 0);
        @(negedge clk); chk("R9 rdata idle", bus_rdata, 0);
    endtask

    task automatic t_free;
        logic [31:0] a, b, h;
        rd(8'h24, a);
        repeat (5 * DIV - 2) @(negedge clk);
        rd(8'h24, b);
        chk("R1 free count step of 5", b - a, 5);
        rd(8'h28, h); chk("R2 high shadow", h, 0);
        rd(8'h24, a);
        repeat (11 * DIV - 2) @(negedge clk);
        rd(8'h24, b);
        chk("R1 free count step of 11", b - a, 11);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(8'h00, 32'hDEAD_BEEF);
        rd(8'h00, v); chk("R3 staged low readback", v, 32'hDEAD_BEEF);
        wr(8'h04, 32'h5000_0000 | 32'h00AB_CDEF);
        rd(8'h04, v); chk("R10 control readback", v, 32'h10AB_CDEF);
        repeat (4 * DIV) @(negedge clk);
        rd(8'h34, v); chk("R4 no count without enable", v, 0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'h2C, 32'h2);
        rd(8'h2C, v); chk("R7 set ignores bit0 clear", v, 0);
        wr(8'h2C, 32'h1);
        rd(8'h2C, v); chk("R7 mask set", v, 1);
        rd(8'h30, v); chk("R7 mask via clear offset", v, 1);
        wr(8'h30, 32'hFFFF_FFFE);
        rd(8'h30, v); chk("R7 clear ignores bit0 clear", v, 1);
        wr(8'h30, 32'h1);
        rd(8'h2C, v); chk("R7 mask cleared", v, 0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        bit seen;
        int t0;
        wr(8'h2C, 32'h1);
        wr(8'h00, 32'd5);
        wr(8'h04, 32'h4100_0000);
        t0 = cyc;
        wait_irq(20 * DIV, seen);
        chk("R4 one-shot fired", seen, 1);
        chk_rng("R4 one-shot latency", cyc - t0, 4 * DIV + 1, 5 * DIV);
        rd(8'h04, v); chk("R10 run cleared after one-shot", v & 32'h0100_0000, 0);
        wr(8'h34, 32'h1);
        @(negedge clk); chk("R8 irq low after clear", irq, 0);
        rd(8'h34, v); chk("R8 pending cleared", v, 0);
        repeat (20 * DIV) @(negedge clk);
        rd(8'h34, v); chk("R4 one-shot does not refire", v, 0);
    endtask

    task automatic t_masked_pend;
        logic [31:0] v;
        wr(8'h30, 32'h1);
        wr(8'h00, 32'd3);
        wr(8'h04, 32'h4100_0000);
        repeat (3 * DIV + 4) @(negedge clk);
        chk("R8 irq held low while masked", irq, 0);
        rd(8'h34, v); chk("R8 pending while masked", v, 1);
        wr(8'h2C, 32'h1);
        @(negedge clk); chk("R8 irq after unmask", irq, 1);
        wr(8'h34, 32'h1);
        @(negedge clk); chk("R8 irq after clear", irq, 0);
    endtask

    task automatic t_repeat;
        logic [31:0] v;
        bit seen;
        int t1, t2, t3;
        wr(8'h00, 32'd6);
        wr(8'h04, 32'h5100_0000);
        wait_irq(20 * DIV, seen); t1 = cyc;
        wr(8'h34, 32'h1);
        wait_irq(20 * DIV, seen); t2 = cyc;
        chk("R5 repeat second expiry", seen, 1);
        wr(8'h34, 32'h1);
        wait_irq(20 * DIV, seen); t3 = cyc;
        chk("R5 repeat period 1", t2 - t1, 6 * DIV);
        chk("R5 repeat period 2", t3 - t2, 6 * DIV);
        wr(8'h04, 32'h0);
        wr(8'h34, 32'h1);
        repeat (20 * DIV) @(negedge clk);
        rd(8'h34, v); chk("R6 stopped after zero write", v, 0);
        rd(8'h04, v); chk("R6 control reads zero", v, 0);
    endtask

    task automatic t_upper;
        logic [31:0] v;
        wr(8'h00, 32'd2);
        wr(8'h04, 32'h4100_0001);
        repeat (10 * DIV) @(negedge clk);
        rd(8'h34, v); chk("R3 upper reload bits counted", v, 0);
        wr(8'h04, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_free;
        t_readback;
        t_mask;
        t_oneshot;
        t_masked_pend;
        t_repeat;
        t_upper;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule